// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small microcontroller run and when the core is held in reset. Software raises one of two request bits. The idle request stops only the processor clock, so timers, the serial port, the interrupt logic and RAM keep working. The power-down request stops the oscillator and so stops everything. The block itself runs on an always-on clock `clk`. Its reset input `hw_rst_n` is assumed to be synchronous to that clock.

Idle ends when an enabled interrupt is pending, or when a hardware reset arrives. Power-down can only be left through a hardware reset. Leaving power-down uses a cold restart: the oscillator is switched on at once, and the reset to the core is held until a parameterised settling count has elapsed. This holds even when the external reset pulse is shorter than that count.

When a hardware reset ends idle, the processor clock runs for `RST_LAG` cycles before the core reset takes hold. During those cycles RAM writes are blocked and port writes are not. The core reset only reinitialises registers; nothing in this block ever clears RAM.

Top module: `lpm_ctrl`

## Requirements
- R1: Running state: with `hw_rst_n` high and neither request set, the five outputs stay at the running pattern. In the order {cpu_clk_en, periph_clk_en, osc_run, core_rst, ram_wr_blk} that pattern is 1,1,1,0,0.
- R2: An idle request that arrives alone while running gives the idle pattern 0,1,1,0,0 from the next cycle on.
- R3: In idle, only `irq_pend` ends the mode, and the running pattern returns one cycle later. While `irq_pend` is low, the request bits have no effect and idle holds.
- R4: A power-down request while running gives 0,0,0,0,0 from the next cycle on: the oscillator, processor and peripheral clocks all stop.
- R5: When both requests are set in the same cycle, power-down wins.
- R6: In power-down, `irq_pend`, `req_idle` and `req_pdown` have no effect. The pattern stays 0,0,0,0,0 until `hw_rst_n` goes low.
- R7: A reset held for L cycles in power-down turns on `osc_run` and `core_rst` in the next cycle. `core_rst` then stays high for max(STAB_CYCLES+1, L) cycles and is followed by the running pattern. A reset held from start-up behaves as a cold restart.
- R8: A reset held for L cycles while running asserts `core_rst` in the next cycle with all clocks on. `core_rst` stays high for exactly L cycles, after which the block is running again.
- R9: A reset held for L cycles in idle first gives RST_LAG cycles of pattern 1,1,1,0,1 (processor clocked, RAM writes blocked, core not yet reset). Then `core_rst` is high for max(1, L-RST_LAG) cycles, and the block is running again.
- R10: `core_rst` is never asserted in idle or power-down, so register and RAM contents are retained. `ram_wr_blk` appears only inside the window of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| hw_rst_n | input | 1 | Hardware reset, active low, synchronous to clk |
| req_idle | input | 1 | Software request to enter idle |
| req_pdown | input | 1 | Software request to enter power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Register reset to the core (RAM untouched) |
| ram_wr_blk | output | 1 | Blocks internal RAM writes |

## Verification
All four combinations of the two request bits are applied from the running state. This separates idle entry from power-down entry and shows that power-down takes priority. All eight combinations of interrupt and request bits are applied in idle and again in power-down. These show that only the interrupt wakes idle and that power-down ignores all of them. Reset lengths are swept from short to longer than the settling count in power-down, running and idle. This separates the cold wait from the warm reset and from the delayed reset with RAM writes blocked.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int STAB_CYCLES = 1024,
  parameter int RST_LAG     = 2
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic req_idle,
  input  logic req_pdown,
  input  logic irq_pend,
  output logic cpu_clk_en,
  output logic periph_clk_en,
  output logic osc_run,
  output logic core_rst,
  output logic ram_wr_blk
);
  localparam int MAXC = (STAB_CYCLES > RST_LAG) ? STAB_CYCLES : RST_LAG;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STAB_V  = CW'(STAB_CYCLES);
  localparam logic [CW-1:0] LAG_END = CW'(RST_LAG - 1);

  typedef enum logic [2:0] {
    S_RST  = 3'd0,
    S_RUN  = 3'd1,
    S_IDLE = 3'd2,
    S_PD   = 3'd3,
    S_LAG  = 3'd4
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    case (st)
      S_RUN: begin
        if (!hw_rst_n) begin
          st  <= S_RST;
          cnt <= STAB_V;
        end else if (req_pdown) begin
          st <= S_PD;
        end else if (req_idle) begin
          st <= S_IDLE;
        end
      end
      S_IDLE: begin
        if (!hw_rst_n) begin
          st  <= S_LAG;
          cnt <= '0;
        end else if (irq_pend) begin
          st <= S_RUN;
        end
      end
      S_LAG: begin
        if (cnt == LAG_END) begin
          st  <= S_RST;
          cnt <= STAB_V;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      S_PD: begin
        if (!hw_rst_n) begin
          st  <= S_RST;
          cnt <= '0;
        end
      end
      S_RST: begin
        if (hw_rst_n && cnt == STAB_V) st <= S_RUN;
        else if (cnt != STAB_V)        cnt <= cnt + 1'b1;
      end
      default: begin
        st  <= S_RST;
        cnt <= '0;
      end
    endcase
  end

  assign cpu_clk_en    = (st == S_RUN) || (st == S_RST) || (st == S_LAG);
  assign periph_clk_en = (st != S_PD);
  assign osc_run       = (st != S_PD);
  assign core_rst      = (st == S_RST);
  assign ram_wr_blk    = (st == S_LAG);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int STAB_CYCLES = 1024
) (
  input logic clk,
  input logic hw_rst_n,
  input logic req_idle,
  input logic req_pdown,
  input logic irq_pend,
  input logic cpu_clk_en,
  input logic periph_clk_en,
  input logic osc_run,
  input logic core_rst,
  input logic ram_wr_blk
);
  logic run_s, idle_s, cold;
  int   since_osc;

  assign run_s  = cpu_clk_en && periph_clk_en && osc_run && !core_rst && !ram_wr_blk;
  assign idle_s = !cpu_clk_en && periph_clk_en;

  always_ff @(posedge clk) begin
    if (!osc_run)                  since_osc <= 0;
    else if (since_osc < STAB_CYCLES + 4) since_osc <= since_osc + 1;
    if (!osc_run)                  cold <= 1'b1;
    else if (!core_rst)            cold <= 1'b0;
  end

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!hw_rst_n)
    run_s && req_idle && !req_pdown |=> idle_s); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!hw_rst_n)
    idle_s && !irq_pend |=> idle_s); // R3
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!hw_rst_n)
    idle_s && irq_pend |=> run_s); // R3
  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!hw_rst_n)
    run_s && req_pdown |=> !osc_run && !cpu_clk_en); // R5
  AST_PD_STAY: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !osc_run |=> !osc_run); // R6
  AST_COLD_WAIT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $fell(core_rst) && cold |-> since_osc >= STAB_CYCLES); // R7
  AST_BLK_WINDOW: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ram_wr_blk |-> cpu_clk_en && !core_rst); // R9
  AST_RETAIN: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (idle_s || !osc_run) |-> !core_rst && !ram_wr_blk); // R10
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.STAB_CYCLES(STAB_CYCLES)) u_lpm_ctrl_chk (
  .clk(clk), .hw_rst_n(hw_rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
  .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .osc_run(osc_run), .core_rst(core_rst), .ram_wr_blk(ram_wr_blk)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  localparam int STAB = 6;
  localparam int LAG  = 2;
  localparam logic [4:0] P_RUN  = 5'b11100;
  localparam logic [4:0] P_IDLE = 5'b01100;
  localparam logic [4:0] P_PD   = 5'b00000;
  localparam logic [4:0] P_RST  = 5'b11110;
  localparam logic [4:0] P_LAG  = 5'b11101;

  logic clk = 1'b0;
  logic hw_rst_n = 1'b0;
  logic req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0;
  logic cpu_clk_en, periph_clk_en, osc_run, core_rst, ram_wr_blk;
  logic [4:0] o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl #(.STAB_CYCLES(STAB), .RST_LAG(LAG)) i_lpm_ctrl (
    .clk(clk), .hw_rst_n(hw_rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
    .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_run(osc_run), .core_rst(core_rst), .ram_wr_blk(ram_wr_blk)
  );

  assign o = {cpu_clk_en, periph_clk_en, osc_run, core_rst, ram_wr_blk};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_reset(input int len, output int lagc, output int rstc);
    lagc = 0; rstc = 0;
    hw_rst_n = 1'b0;
    for (int k = 1; k < 100; k++) begin
      step();
      if (o == P_LAG) lagc++;
      if (core_rst) rstc++;
      if (k == len) hw_rst_n = 1'b1;
      if (k >= len && o == P_RUN) break;
    end
    hw_rst_n = 1'b1;
  endtask

  task automatic go_run();
    int a, b;
    if (o == P_IDLE) begin
      irq_pend = 1'b1; step(); irq_pend = 1'b0;
    end else if (o != P_RUN) begin
      pulse_reset(1, a, b);
    end
  endtask

  task automatic enter(input bit pd);
    go_run();
    req_pdown = pd; req_idle = !pd; step();
    req_pdown = 1'b0; req_idle = 1'b0;
  endtask

  initial begin
    int lc, rc, e;
    for (int k = 0; k < 20; k++) step();
    chk("R7 start-up reset holds core", o, P_RST);
    hw_rst_n = 1'b1; step();
    chk("R7 start-up release", o, P_RUN);
    for (int k = 0; k < 3; k++) step();
    chk("R1 run holds", o, P_RUN);

    for (int c = 0; c < 4; c++) begin
      go_run();
      req_idle = c[0]; req_pdown = c[1]; step();
      req_idle = 1'b0; req_pdown = 1'b0;
      e = (c == 0) ? P_RUN : (c == 1) ? P_IDLE : P_PD;
      if (c == 0) chk("R1 no request", o, e);
      else if (c == 1) chk("R2 idle entry", o, e);
      else if (c == 2) chk("R4 power-down entry", o, e);
      else chk("R5 power-down priority", o, e);
      step();
      chk("R10 pattern holds", o, e);
    end

    for (int c = 0; c < 8; c++) begin
      enter(1'b0);
      irq_pend = c[2]; req_idle = c[1]; req_pdown = c[0]; step();
      irq_pend = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;
      chk("R3 idle wake only by interrupt", o, c[2] ? P_RUN : P_IDLE);
    end

    enter(1'b1);
    for (int c = 0; c < 8; c++) begin
      irq_pend = c[2]; req_idle = c[1]; req_pdown = c[0]; step();
      chk("R6 power-down ignores inputs", o, P_PD);
    end
    irq_pend = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;

    for (int len = 1; len <= STAB + 3; len++) begin
      enter(1'b1);
      hw_rst_n = 1'b0; step();
      chk("R7 oscillator restarts with reset", o, P_RST);
      hw_rst_n = 1'b1;
      enter(1'b1);
      pulse_reset(len, lc, rc);
      chk("R7 cold reset hold", rc, (len > STAB + 1) ? len : STAB + 1);
      chk("R7 running after cold reset", o, P_RUN);
    end

    for (int len = 1; len <= 4; len++) begin
      go_run();
      pulse_reset(len, lc, rc);
      chk("R8 warm reset hold", rc, len);
      chk("R8 no blocking window", lc, 0);
      chk("R8 running after warm reset", o, P_RUN);
    end

    for (int len = 1; len <= 6; len++) begin
      enter(1'b0);
      pulse_reset(len, lc, rc);
      chk("R9 RAM write block window", lc, LAG);
      chk("R9 reset hold after idle", rc, (len - LAG > 1) ? len - LAG : 1);
      chk("R9 running after idle reset", o, P_RUN);
    end

    enter(1'b0);
    hw_rst_n = 1'b0; step();
    chk("R9 first cycle clocked and blocked", o, P_LAG);
    hw_rst_n = 1'b1;
    for (int k = 0; k < 20; k++) step();
    chk("R10 no block outside window", o, P_RUN);

    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 20000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule